// File: doc/BRIEF.md
# Timer Control Register with Field Locking

This block is the main control word of a timer/counter peripheral. Software reaches it through a plain register-bus port with separate write and read strobes, an address and 32-bit data. It holds the configuration for two capture channels, DMA trigger mode, auto-lock, the prescaler, clock-request behaviour, standby behaviour, prescaler synchronisation and counter width. It also holds the enable and software-reset controls. Every field is decoded and driven out as its own port, so the counter, capture and DMA logic next to it can use the values directly.

Configuration fields are locked while the timer is running or changing state. The enable and software-reset controls are modelled as crossing into a slower clock domain. Each one raises a busy flag that stays high for a fixed number of cycles. A software reset wins over everything else written in the same access, and the bus is refused until the reset has settled. Reserved codes in the counter-width and sync fields are rejected, so the fields keep their previous values. The on-demand output is masked while the system is in standby and standby running is not allowed.

Top module: `tmr_ctrl_reg`

## Requirements
- R1: After reset every exported field, the enable output and both busy flags are 0. A read of the register returns 0x00000000.
- R2: The register sits at offset 0. While the block is unlocked, a write updates the fields at these positions, and a read returns them at the same positions:
  - channel 1 capture mode at [28:27]
  - channel 0 capture mode at [25:24]
  - capture-from-pin select at [21:20] (bit 20 is channel 0)
  - capture enables at [17:16] (bit 16 is channel 0)
  - DMA one-shot at 15
  - auto-lock at 11
  - prescaler select at [10:8]
  - on-demand at 7
  - standby-run at 6
  - prescaler sync at [5:4]
  - counter width at [3:2]
  - enable at 1 (this bit reads the effective enable)

  All other bits read as 0.
- R3: While the effective enable is 1 or the enable busy flag is set, writes leave every configuration field unchanged.
- R4: A write with bit 0 set clears every field and the enable, cancels any enable change in progress, and discards the other written bits. From the next cycle the reset busy flag stays high for exactly 3 cycles.
- R5: A write with bit 0 clear causes no reset. The other written bits are handled normally.
- R6: A write whose bit 1 differs from the current enable sets the enable busy flag on the next cycle. Exactly 3 cycles after the write edge, the busy flag clears and the enable output takes the new value on the same edge. Bit 1 of writes made while the enable busy flag is set is ignored.
- R7: While the reset busy flag is set, any write or read strobe raises the refuse output in the same cycle, reads return 0, and writes have no effect.
- R8: Counter-width codes are 0 = 16-bit, 1 = 8-bit and 2 = 32-bit. Sync codes are 0 = generic clock, 1 = prescaled clock and 2 = resync. A written code of 3 in either field leaves that field at its previous value.
- R9: When the standby input is 1 and standby-run is 0, the on-demand output and read bit 7 are 0. The stored value returns when that condition ends.
- R10: Writes to any address other than offset 0 have no effect, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_refuse | output | 1 | Access refused because a reset is settling |
| standby | input | 1 | System standby indication |
| capt_mode_o | output | 4 | Capture mode, channel 1 in [3:2], channel 0 in [1:0] |
| capt_pin_o | output | 2 | Capture source is a pin, one bit per channel |
| capt_en_o | output | 2 | Capture enable, one bit per channel |
| dma_oneshot_o | output | 1 | DMA one-shot trigger mode |
| auto_lock_o | output | 1 | Auto-lock |
| presc_sel_o | output | 3 | Prescaler select |
| on_demand_o | output | 1 | On-demand clock request, masked per R9 |
| run_stdby_o | output | 1 | Keep running in standby |
| presc_sync_o | output | 2 | Prescaler sync select |
| cnt_mode_o | output | 2 | Counter width |
| enable_o | output | 1 | Effective enable |
| en_busy_o | output | 1 | Enable change in progress |
| rst_busy_o | output | 1 | Software reset in progress |

## Verification
Directed sequences cover several cases:
- writes with the block unlocked, which show the field positions;
- reserved width and sync codes written after legal ones, which separate "keep old value" from "store the code";
- field writes during the enable handshake and while running, which separate the lock window from the effective enable alone;
- a reset write with every bit set, followed at once by accesses, which shows reset precedence and refusal.

A long random run then mixes the following, all compared cycle by cycle against a bench model:
- mostly-matching addresses with stray offsets;
- rare reset writes;
- random enable flips that land inside busy windows;
- toggling standby.

The random run exposes ordering faults between the handshake completion, new writes and reset that the directed cases do not reach.

// File: rtl/tmr_ctrl_pkg.sv
package tmr_ctrl_pkg;

  localparam int unsigned CR_W   = 32;
  localparam int unsigned CAP_CH = 2;

  // bit positions of the control word
  localparam int unsigned B_SWRST     = 0;
  localparam int unsigned B_EN        = 1;
  localparam int unsigned B_MODE      = 2;
  localparam int unsigned B_PSYNC     = 4;
  localparam int unsigned B_STDBY     = 6;
  localparam int unsigned B_ONDEM     = 7;
  localparam int unsigned B_PRESC     = 8;
  localparam int unsigned B_ALOCK     = 11;
  localparam int unsigned B_DMAOS     = 15;
  localparam int unsigned B_CAPEN     = 16;
  localparam int unsigned B_CAPPIN    = 20;
  localparam int unsigned B_CAPMODE   = 24;
  localparam int unsigned CAPM_STRIDE = 3;

  typedef enum logic [1:0] {
    CW_16B  = 2'd0,
    CW_8B   = 2'd1,
    CW_32B  = 2'd2,
    CW_RSVD = 2'd3
  } cnt_width_e;

  typedef enum logic [1:0] {
    PSY_GCLK   = 2'd0,
    PSY_PRESC  = 2'd1,
    PSY_RESYNC = 2'd2,
    PSY_RSVD   = 2'd3
  } presc_sync_e;

  typedef struct packed {
    logic [CAP_CH-1:0][1:0] capt_mode;
    logic [CAP_CH-1:0]      capt_pin;
    logic [CAP_CH-1:0]      capt_en;
    logic                   dma_os;
    logic                   auto_lock;
    logic [2:0]             presc;
    logic                   on_demand;
    logic                   run_stdby;
    presc_sync_e            psync;
    cnt_width_e             cmode;
  } ctrl_fields_t;

endpackage

// File: rtl/tmr_ctrl_sync.sv
// Fixed-latency handshake model: busy rises on start, falls DELAY edges later.
module tmr_ctrl_sync #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic flush,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign upd    = flush | start | busy_q;
  assign done_o = busy_q & (cnt_q == '0) & ~flush;
  assign busy_o = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (flush) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/tmr_ctrl_fields.sv
// Storage for the lockable configuration fields.
module tmr_ctrl_fields
  import tmr_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            wr_ok,
  input  logic [CR_W-1:0] wdata,
  output ctrl_fields_t    fields_o
);

  ctrl_fields_t f_q, f_d;

  logic [CAP_CH-1:0][1:0] cm_d;
  logic [CAP_CH-1:0]      pin_d;
  logic [CAP_CH-1:0]      cen_d;
  logic                   unused_wbits;

  assign unused_wbits = ^{wdata[31:29], wdata[26], wdata[23:22], wdata[19:18],
                          wdata[14:12], wdata[B_EN], wdata[B_SWRST]};

  generate
    for (genvar ch = 0; ch < CAP_CH; ch++) begin : g_ch
      assign cm_d[ch]  = wr_ok ? wdata[B_CAPMODE + CAPM_STRIDE*ch +: 2] : f_q.capt_mode[ch];
      assign pin_d[ch] = wr_ok ? wdata[B_CAPPIN + ch] : f_q.capt_pin[ch];
      assign cen_d[ch] = wr_ok ? wdata[B_CAPEN + ch]  : f_q.capt_en[ch];
    end
  endgenerate

  always_comb begin
    f_d           = f_q;
    f_d.capt_mode = cm_d;
    f_d.capt_pin  = pin_d;
    f_d.capt_en   = cen_d;
    if (wr_ok) begin
      f_d.dma_os    = wdata[B_DMAOS];
      f_d.auto_lock = wdata[B_ALOCK];
      f_d.presc     = wdata[B_PRESC +: 3];
      f_d.on_demand = wdata[B_ONDEM];
      f_d.run_stdby = wdata[B_STDBY];
      if (wdata[B_PSYNC +: 2] != PSY_RSVD)
        f_d.psync = presc_sync_e'(wdata[B_PSYNC +: 2]);
      if (wdata[B_MODE +: 2] != CW_RSVD)
        f_d.cmode = cnt_width_e'(wdata[B_MODE +: 2]);
    end
    if (clr) f_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             f_q <= '0;
    else if (clr || wr_ok)  f_q <= f_d;
  end

  assign fields_o = f_q;

endmodule

// File: rtl/tmr_ctrl_rdmux.sv
// Read word assembly and standby masking of the clock-request bit.
module tmr_ctrl_rdmux
  import tmr_ctrl_pkg::*;
(
  input  ctrl_fields_t    fields,
  input  logic            en,
  input  logic            standby,
  input  logic            rd_hit,
  output logic [CR_W-1:0] rdata_o,
  output logic            on_demand_eff_o
);

  logic [CR_W-1:0] word;

  assign on_demand_eff_o = fields.on_demand & ~(standby & ~fields.run_stdby);

  always_comb begin
    word = '0;
    for (int ch = 0; ch < CAP_CH; ch++) begin
      word[B_CAPMODE + CAPM_STRIDE*ch +: 2] = fields.capt_mode[ch];
      word[B_CAPPIN + ch]                   = fields.capt_pin[ch];
      word[B_CAPEN + ch]                    = fields.capt_en[ch];
    end
    word[B_DMAOS]       = fields.dma_os;
    word[B_ALOCK]       = fields.auto_lock;
    word[B_PRESC +: 3]  = fields.presc;
    word[B_ONDEM]       = on_demand_eff_o;
    word[B_STDBY]       = fields.run_stdby;
    word[B_PSYNC +: 2]  = fields.psync;
    word[B_MODE +: 2]   = fields.cmode;
    word[B_EN]          = en;
  end

  assign rdata_o = rd_hit ? word : '0;

endmodule

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_ctrl_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] REG_OFS  = '0,
  parameter int unsigned       SYNC_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CR_W-1:0]       bus_wdata,
  output logic [CR_W-1:0]       bus_rdata,
  output logic                  bus_refuse,
  input  logic                  standby,
  output logic [2*CAP_CH-1:0]   capt_mode_o,
  output logic [CAP_CH-1:0]     capt_pin_o,
  output logic [CAP_CH-1:0]     capt_en_o,
  output logic                  dma_oneshot_o,
  output logic                  auto_lock_o,
  output logic [2:0]            presc_sel_o,
  output logic                  on_demand_o,
  output logic                  run_stdby_o,
  output logic [1:0]            presc_sync_o,
  output logic [1:0]            cnt_mode_o,
  output logic                  enable_o,
  output logic                  en_busy_o,
  output logic                  rst_busy_o
);

  logic         addr_hit, wr_acc, swrst_wr, norm_wr, locked, fld_wr, rd_hit;
  logic         en_start, en_done, en_busy, rst_busy, rst_done_unused;
  logic         en_q, en_d, tgt_q, tgt_d, en_upd;
  ctrl_fields_t fields;

  // bus decode
  assign addr_hit = (bus_addr == REG_OFS);
  assign wr_acc   = bus_wr & addr_hit & ~rst_busy;
  assign swrst_wr = wr_acc &  bus_wdata[B_SWRST];
  assign norm_wr  = wr_acc & ~bus_wdata[B_SWRST];
  assign locked   = en_q | en_busy;
  assign fld_wr   = norm_wr & ~locked;
  assign rd_hit   = bus_rd & addr_hit & ~rst_busy;
  assign bus_refuse = (bus_wr | bus_rd) & rst_busy;

  // enable request / effective value
  assign en_start = norm_wr & ~en_busy & (bus_wdata[B_EN] != en_q);
  assign en_upd   = swrst_wr | en_start | en_done;

  always_comb begin
    en_d  = en_q;
    tgt_d = tgt_q;
    if (swrst_wr) begin
      en_d  = 1'b0;
      tgt_d = 1'b0;
    end else if (en_start) begin
      tgt_d = bus_wdata[B_EN];
    end else if (en_done) begin
      en_d  = tgt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tgt_q <= 1'b0;
    end else if (en_upd) begin
      en_q  <= en_d;
      tgt_q <= tgt_d;
    end
  end

  tmr_ctrl_sync #(.DELAY(SYNC_CYC)) u_en_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (en_start),
    .flush  (swrst_wr),
    .busy_o (en_busy),
    .done_o (en_done)
  );

  tmr_ctrl_sync #(.DELAY(SYNC_CYC)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (swrst_wr),
    .flush  (1'b0),
    .busy_o (rst_busy),
    .done_o (rst_done_unused)
  );

  tmr_ctrl_fields u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (swrst_wr),
    .wr_ok    (fld_wr),
    .wdata    (bus_wdata),
    .fields_o (fields)
  );

  tmr_ctrl_rdmux u_rdmux (
    .fields          (fields),
    .en              (en_q),
    .standby         (standby),
    .rd_hit          (rd_hit),
    .rdata_o         (bus_rdata),
    .on_demand_eff_o (on_demand_o)
  );

  // decoded field outputs
  assign capt_mode_o   = fields.capt_mode;
  assign capt_pin_o    = fields.capt_pin;
  assign capt_en_o     = fields.capt_en;
  assign dma_oneshot_o = fields.dma_os;
  assign auto_lock_o   = fields.auto_lock;
  assign presc_sel_o   = fields.presc;
  assign run_stdby_o   = fields.run_stdby;
  assign presc_sync_o  = fields.psync;
  assign cnt_mode_o    = fields.cmode;
  assign enable_o      = en_q;
  assign en_busy_o     = en_busy;
  assign rst_busy_o    = rst_busy;

endmodule

// File: rtl/tmr_ctrl_chk.sv
module tmr_ctrl_chk #(
  parameter int unsigned       ADDR_W  = 4,
  parameter logic [ADDR_W-1:0] REG_OFS = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        wr_lo,
  input logic [31:0]       bus_rdata,
  input logic              bus_refuse,
  input logic              standby,
  input logic              on_demand_o,
  input logic              run_stdby_o,
  input logic [2:0]        presc_sel_o,
  input logic [1:0]        capt_en_o,
  input logic [1:0]        presc_sync_o,
  input logic [1:0]        cnt_mode_o,
  input logic              enable_o,
  input logic              en_busy_o,
  input logic              rst_busy_o
);

  logic wr_ok;
  assign wr_ok = bus_wr && (bus_addr == REG_OFS) && !rst_busy_o;

  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && wr_lo[0] |=> rst_busy_o && !enable_o && !en_busy_o &&
                          cnt_mode_o == 2'b00 && presc_sel_o == 3'd0); // R4

  AST_EN_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !wr_lo[0] && !en_busy_o && (wr_lo[1] != enable_o) |=> en_busy_o); // R6

  AST_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_busy_o) && !rst_busy_o |-> $stable(enable_o)); // R6

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !wr_lo[0] && (enable_o || en_busy_o) |=>
      $stable(cnt_mode_o) && $stable(presc_sel_o) && $stable(capt_en_o)); // R3

  AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy_o && (bus_wr || bus_rd) |-> bus_refuse); // R7

  AST_REFUSE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy_o |-> bus_rdata == 32'd0); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mode_o != 2'b11 && presc_sync_o != 2'b11); // R8

  AST_ONDEMAND_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    standby && !run_stdby_o |-> !on_demand_o); // R9

  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr != REG_OFS) |-> bus_rdata == 32'd0); // R10

endmodule

bind tmr_ctrl_reg tmr_ctrl_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .wr_lo        (bus_wdata[1:0]),
  .bus_rdata    (bus_rdata),
  .bus_refuse   (bus_refuse),
  .standby      (standby),
  .on_demand_o  (on_demand_o),
  .run_stdby_o  (run_stdby_o),
  .presc_sel_o  (presc_sel_o),
  .capt_en_o    (capt_en_o),
  .presc_sync_o (presc_sync_o),
  .cnt_mode_o   (cnt_mode_o),
  .enable_o     (enable_o),
  .en_busy_o    (en_busy_o),
  .rst_busy_o   (rst_busy_o)
);

// File: tb/tmr_ctrl_reg_bench.sv
`timescale 1ns/1ps
module tmr_ctrl_reg_bench;

  localparam int unsigned AW = 4;
  localparam logic [31:0] LOCK_MASK = 32'h1B33_8FFC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_wr, bus_rd, standby;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          bus_refuse;
  logic [3:0]    capt_mode_o;
  logic [1:0]    capt_pin_o, capt_en_o, presc_sync_o, cnt_mode_o;
  logic          dma_oneshot_o, auto_lock_o, on_demand_o, run_stdby_o;
  logic [2:0]    presc_sel_o;
  logic          enable_o, en_busy_o, rst_busy_o;

  always #2 clk = ~clk;

  tmr_ctrl_reg #(.ADDR_W(AW)) u_tmr_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_refuse(bus_refuse), .standby(standby), .capt_mode_o(capt_mode_o),
    .capt_pin_o(capt_pin_o), .capt_en_o(capt_en_o), .dma_oneshot_o(dma_oneshot_o),
    .auto_lock_o(auto_lock_o), .presc_sel_o(presc_sel_o), .on_demand_o(on_demand_o),
    .run_stdby_o(run_stdby_o), .presc_sync_o(presc_sync_o), .cnt_mode_o(cnt_mode_o),
    .enable_o(enable_o), .en_busy_o(en_busy_o), .rst_busy_o(rst_busy_o)
  );

  int unsigned n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  // bench model of the register, built from the requirements
  logic [31:0] m_f;
  logic        m_en, m_tgt, m_ebusy, m_rbusy;
  int          m_ecnt, m_rcnt;

  function automatic logic m_ondem_eff(logic [31:0] f, logic sb);
    return f[7] & ~(sb & ~f[6]);
  endfunction

  function automatic logic [31:0] m_rdword(logic rd, logic [AW-1:0] a, logic sb);
    logic [31:0] w;
    if (!rd || a != '0 || m_rbusy) return 32'd0;
    w = m_f & ~32'h80;
    w[7] = m_ondem_eff(m_f, sb);
    w[1] = m_en;
    return w;
  endfunction

  function automatic logic [18:0] m_outs(logic sb);
    return {m_f[28:27], m_f[25:24], m_f[21:20], m_f[17:16], m_f[15], m_f[11],
            m_f[10:8], m_ondem_eff(m_f, sb), m_f[6], m_f[5:4], m_f[3:2]};
  endfunction

  task automatic model_edge(logic wr, logic [AW-1:0] a, logic [31:0] d);
    logic acc, lck, ebusy_old;
    acc = wr && a == '0 && !m_rbusy;
    if (m_rbusy) begin
      if (m_rcnt == 0) m_rbusy = 1'b0; else m_rcnt--;
    end
    if (acc && d[0]) begin
      m_f = '0; m_en = 1'b0; m_tgt = 1'b0; m_ebusy = 1'b0;
      m_rbusy = 1'b1; m_rcnt = 2;
    end else begin
      lck = m_en | m_ebusy;
      ebusy_old = m_ebusy;
      if (m_ebusy) begin
        if (m_ecnt == 0) begin m_ebusy = 1'b0; m_en = m_tgt; end
        else m_ecnt--;
      end
      if (acc) begin
        if (!lck) begin
          logic [31:0] nf;
          nf = (m_f & ~LOCK_MASK) | (d & LOCK_MASK);
          if (d[3:2] == 2'b11) nf[3:2] = m_f[3:2];
          if (d[5:4] == 2'b11) nf[5:4] = m_f[5:4];
          m_f = nf;
        end
        if (!ebusy_old && d[1] != m_en) begin
          m_tgt = d[1]; m_ebusy = 1'b1; m_ecnt = 2;
        end
      end
    end
  endtask

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // one bus cycle: drive, check combinational response, clock, check state
  task automatic step(string tag, logic wr, logic rd, logic [AW-1:0] a, logic [31:0] d);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    check(tag, "rdata",  bus_rdata, m_rdword(rd, a, standby));
    check(tag, "refuse", 32'(bus_refuse), 32'((wr | rd) & m_rbusy));
    @(posedge clk);
    model_edge(wr, a, d);
    @(negedge clk);
    check(tag, "enable",   32'(enable_o),   32'(m_en));
    check(tag, "en_busy",  32'(en_busy_o),  32'(m_ebusy));
    check(tag, "rst_busy", 32'(rst_busy_o), 32'(m_rbusy));
    check(tag, "fields",
          32'({capt_mode_o, capt_pin_o, capt_en_o, dma_oneshot_o, auto_lock_o,
               presc_sel_o, on_demand_o, run_stdby_o, presc_sync_o, cnt_mode_o}),
          32'(m_outs(standby)));
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b1, '0, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0; standby = 0;
    m_f = '0; m_en = 0; m_tgt = 0; m_ebusy = 0; m_rbusy = 0; m_ecnt = 0; m_rcnt = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check("R1", "rdata_raw", bus_rdata, 32'd0);
    idle("R1", 1);

    // R2: layout, unlocked writes
    step("R2", 1, 0, '0, 32'h1A21_0A58);
    idle("R2", 1);
    step("R2", 1, 0, '0, 32'hE4DE_74A4);
    idle("R2", 1);

    // R8: reserved codes keep the previous value
    step("R8", 1, 0, '0, 32'h0000_0028);
    step("R8", 1, 1, '0, 32'h0000_003C);
    idle("R8", 1);
    check("R8", "mode_kept", 32'(cnt_mode_o), 32'd2);

    // R5: bit 0 clear is a normal write
    step("R5", 1, 0, '0, 32'h0300_0594);
    idle("R5", 1);

    // R9: on-demand masked in standby without standby-run
    standby = 1'b1;
    idle("R9", 1);
    check("R9", "ondemand_masked", 32'(on_demand_o), 32'd0);
    standby = 1'b0;
    idle("R9", 1);

    // R10: foreign offset ignored
    step("R10", 1, 0, 4'd5, 32'hFFFF_FFFC);
    step("R10", 0, 1, 4'd5, 32'd0);
    idle("R10", 1);

    // R6: enable handshake, 3 cycles
    step("R6", 1, 0, '0, 32'h0000_0096);
    idle("R6", 1);
    step("R3", 1, 0, '0, 32'h1B33_8FF2);
    idle("R6", 1);
    check("R6", "enable_after_3", 32'(enable_o), 32'd1);

    // R3: locked while running
    step("R3", 1, 0, '0, 32'h1B33_8FE2);
    idle("R3", 1);

    // R6: disable, then a conflicting write inside the busy window
    step("R6", 1, 0, '0, 32'h0000_0000);
    step("R6", 1, 0, '0, 32'h0000_0002);
    idle("R6", 3);

    // R4 / R7: reset precedence and refusal
    step("R6", 1, 0, '0, 32'h0000_0002);
    step("R4", 1, 0, '0, 32'hFFFF_FFFF);
    step("R7", 1, 1, '0, 32'h0000_0010);
    step("R7", 0, 1, '0, 32'd0);
    idle("R4", 3);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      logic [31:0]   d;
      a = ($urandom % 8 == 0) ? AW'($urandom) : '0;
      d = $urandom;
      d[0] = ($urandom % 40 == 0);
      standby = ($urandom % 4 == 0);
      step("R2", 1'($urandom), 1'($urandom), a, d);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule